// File: doc/BRIEF.md
# PCI Type-0 Configuration Header Register File

This block holds the standard 64-byte configuration header of one PCI function. A bus adapter hands it one access per cycle through a small port: an offset, a byte count, a write flag and write data. The block answers one cycle later with a response strobe, read data and an error flag. The identity fields and the power-up values of the writable registers are parameters. A synchronous active-low reset restores them.

Each write is checked against the target register and the access width. Writes that the header does not allow are dropped and do not raise the error flag. Six base address registers support the usual sizing handshake. Writing all ones to a BAR returns the size mask, and writing an address programs the decode window. Each BAR drives its decoded base address and an enable bit to a downstream address decoder. A one-cycle change pulse tells the decoder that a window has moved. Any BAR can instead be set as a legacy BAR. Such a BAR reads as zero, ignores writes and decodes at a fixed address.

Top module: `cfghdr_regs`

## Requirements
- R1: After reset, reads return the parameter values at the standard header positions: vendor 0x00, device 0x02, command 0x04, status 0x06, revision 0x08, class code 0x09..0x0B, cache line 0x0C, latency 0x0D, header type 0x0E, BIST 0x0F, BARs 0x10..0x27, subsystem IDs 0x2C/0x2E, expansion ROM 0x30, interrupt line/pin 0x3C/0x3D, min grant 0x3E, max latency 0x3F. The reserved bytes read as zero.
- R2: A read of size 1, 2 or 4 returns that many bytes, little-endian, from the header image starting at the offset. The unused upper bytes of the response are zero.
- R3: An access is illegal if its offset is 0x40 or above, its size is not 1, 2 or 4, or it is a 2-byte access at an odd offset or a 4-byte access at an offset not divisible by 4. An illegal access returns rsp_err=1 with rsp_rdata=0 and changes no register.
- R4: A 1-byte write updates only the interrupt line (0x3C), cache line size (0x0C) and latency timer (0x0D). Every other 1-byte write is dropped.
- R5: A 2-byte write updates command (0x04) and status (0x06). A 2-byte write at 0x0C loads the low data byte into the cache line size only. Every other 2-byte write is dropped.
- R6: A 4-byte write at 0x04 loads the command register from data[15:0] and leaves status unchanged. 4-byte writes reach the BARs and the expansion ROM (0x30). Every other 4-byte write is dropped.
- R7: A 4-byte write of 0xFFFFFFFF to a non-legacy BAR makes it read back ~(size-1) in its address bits with its type bits kept. The decode base, the enable and the change pulse are not affected.
- R8: Any other 4-byte BAR write takes its address bits from the data and keeps the type bits of the old value. Bits 1:0 are kept when old bit 0 is 1 (I/O). Bits 3:0 are kept when old bit 0 is 0 (memory).
- R9: An R8 write whose address bits are non-zero loads them into the BAR's decode base and sets its enable, which then stays set. range_change pulses for one cycle, aligned with that write's response. A zero-address write leaves the base, the enable and range_change unchanged.
- R10: A legacy BAR reads zero and ignores all writes. Its decode base is the parameter address, and it is enabled when that address is non-zero.
- R11: A 4-byte write of 0xFFFFFFFE to the expansion ROM register makes it read 0xFFFFFFFF. Any other 4-byte value is stored as written.
- R12: rsp_valid is high exactly in the cycle after each cycle with req_valid high, including back-to-back requests. A read in the cycle after a write sees the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_offset | input | 8 | Byte offset into configuration space |
| req_size | input | 3 | Byte count: 1, 2 or 4 |
| req_wdata | input | 32 | Write data, little-endian, right-aligned |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata | output | 32 | Read data, zero for writes and errors |
| rsp_err | output | 1 | Illegal access flag |
| bar_base | output | 192 | Decode base per BAR, BAR i at bits [32i+31:32i] |
| bar_enable | output | 6 | Decode enable per BAR |
| range_change | output | 1 | One-cycle pulse when a decode window moves |

## Verification
A BAR address write produces both the write's own response and the range_change pulse in the same cycle, so the two are checked together. Each response record in the scoreboard carries the expected pulse value, and every response cycle is compared for data, error and pulse at once. The bench also issues a 4-byte write immediately followed by a read of the same register. The read's response then follows the write's response in the next cycle and must already show the new value. A sizing write and a zero-address write are compared in the same way, where the expected pulse is zero.

// File: rtl/cfghdr_pkg.sv
// Package: shared constants for the configuration header register file.
// Assumes a 64-byte type-0 header with standard field positions.
package cfghdr_pkg;
    localparam int HDR_BYTES = 64;
    localparam int NUM_BARS  = 6;

    typedef enum logic [2:0] {
        SZ_BYTE = 3'd1,
        SZ_HALF = 3'd2,
        SZ_WORD = 3'd4
    } acc_size_e;

    localparam logic [7:0] OFS_CMD      = 8'h04;
    localparam logic [7:0] OFS_STS      = 8'h06;
    localparam logic [7:0] OFS_CLS      = 8'h0C;
    localparam logic [7:0] OFS_LAT      = 8'h0D;
    localparam logic [7:0] OFS_BAR0     = 8'h10;
    localparam logic [7:0] OFS_ROM      = 8'h30;
    localparam logic [7:0] OFS_INT_LINE = 8'h3C;

    localparam logic [31:0] ROM_SIZE_REQ = 32'hFFFF_FFFE;
endpackage

// File: rtl/cfghdr_access_check.sv
// Module: legality check for one configuration access.
// Assumes the size code is a plain byte count. ok is high only for sizes
// 1, 2 and 4 that are naturally aligned and lie inside the header.
module cfghdr_access_check
    import cfghdr_pkg::*;
#(
    parameter int OFS_W = 8,
    parameter int LIMIT = HDR_BYTES
) (
    input  logic [OFS_W-1:0] offset,
    input  logic [2:0]       size,
    output logic             ok
);
    logic in_range;
    logic aligned;

    // Purpose: compare the offset against the header limit and check alignment per size.
    always_comb begin
        in_range = (int'(offset) < LIMIT);
        case (size)
            SZ_BYTE: aligned = 1'b1;
            SZ_HALF: aligned = ~offset[0];
            SZ_WORD: aligned = (offset[1:0] == 2'b00);
            default: aligned = 1'b0;
        endcase
        ok = in_range && aligned;
    end
endmodule

// File: rtl/cfghdr_bar.sv
// Module: one base address register with sizing and decode output.
// Assumes wr_en marks a legal 4-byte write aimed at this BAR. SIZE must be
// zero or a power of two. A LEGACY BAR reads zero, drops writes, and decodes
// at LEGACY_ADDR.
module cfghdr_bar #(
    parameter logic [31:0] INIT        = 32'h0,
    parameter logic [31:0] SIZE        = 32'h0,
    parameter bit          LEGACY      = 1'b0,
    parameter logic [31:0] LEGACY_ADDR = 32'h0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wdata,
    output logic [31:0] reg_val,
    output logic [31:0] base,
    output logic        enable,
    output logic        chg
);
    localparam logic [31:0] SIZE_MASK = ~(SIZE - 32'd1);

    if (!LEGACY && SIZE != 0 && (SIZE & (SIZE - 32'd1)) != 0) begin : g_bad_size
        $error("cfghdr_bar: SIZE must be zero or a power of two");
    end

    logic [31:0] bar_q;
    logic [31:0] base_q;
    logic        active_q;
    logic        chg_q;
    logic        wr_eff;
    logic        sizing;
    logic [31:0] keep;
    logic [31:0] new_addr;

    // Purpose: pick the kept type bits and form the new address bits.
    always_comb begin
        wr_eff   = wr_en && !LEGACY;
        sizing   = (wdata == 32'hFFFF_FFFF);
        keep     = bar_q[0] ? 32'h0000_0003 : 32'h0000_000F;
        new_addr = sizing ? (SIZE_MASK & ~keep) : (wdata & ~keep);
    end

    // Purpose: update the BAR value, its decode window and the change pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bar_q    <= INIT;
            base_q   <= 32'h0;
            active_q <= 1'b0;
            chg_q    <= 1'b0;
        end else begin
            chg_q <= 1'b0;
            if (wr_eff) begin
                bar_q <= new_addr | (bar_q & keep);
                if (!sizing && new_addr != 32'h0) begin
                    base_q   <= new_addr;
                    active_q <= 1'b1;
                    chg_q    <= 1'b1;
                end
            end
        end
    end

    // Purpose: select legacy constants or live state for the outputs.
    always_comb begin
        reg_val = LEGACY ? 32'h0 : bar_q;
        base    = LEGACY ? LEGACY_ADDR : base_q;
        enable  = LEGACY ? (LEGACY_ADDR != 32'h0) : active_q;
        chg     = LEGACY ? 1'b0 : chg_q;
    end

    p_sizing_keeps_base_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_eff && wdata == 32'hFFFF_FFFF) |=> ($stable(base_q) && !chg_q));

    p_type_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_eff |=> ((bar_q & $past(keep)) == ($past(bar_q) & $past(keep))));

    p_enable_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        active_q |=> active_q);

    p_pulse_needs_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        chg_q |-> $past(wr_eff));
endmodule

// File: rtl/cfghdr_regs.sv
// Module: type-0 configuration header register file of one PCI function.
// Assumes one access per cycle, answered one cycle later. Write filtering
// follows the register and width. Six BARs feed a downstream decoder.
module cfghdr_regs
    import cfghdr_pkg::*;
#(
    parameter logic [15:0]  VENDOR_ID     = 16'hA5C3,
    parameter logic [15:0]  DEVICE_ID     = 16'h0417,
    parameter logic [15:0]  CMD_INIT      = 16'h0000,
    parameter logic [15:0]  STS_INIT      = 16'h0290,
    parameter logic [7:0]   REVISION      = 8'h02,
    parameter logic [23:0]  CLASS_CODE    = 24'h028000,
    parameter logic [7:0]   CLS_INIT      = 8'h00,
    parameter logic [7:0]   LAT_INIT      = 8'h00,
    parameter logic [7:0]   HDR_TYPE      = 8'h00,
    parameter logic [7:0]   BIST_VAL      = 8'h00,
    parameter logic [31:0]  CIS_PTR       = 32'h0,
    parameter logic [15:0]  SUBSYS_VID    = 16'hA5C3,
    parameter logic [15:0]  SUBSYS_ID     = 16'h0001,
    parameter logic [31:0]  ROM_INIT      = 32'h0,
    parameter logic [7:0]   INT_LINE_INIT = 8'h0B,
    parameter logic [7:0]   INT_PIN       = 8'h01,
    parameter logic [7:0]   MIN_GRANT     = 8'h04,
    parameter logic [7:0]   MAX_LATENCY   = 8'h10,
    parameter logic [191:0] BAR_INIT      = {32'h1, 32'h0, 32'h0, 32'h8, 32'h1, 32'h0},
    parameter logic [191:0] BAR_SIZE      = {32'h20, 32'h0, 32'h8, 32'h0010_0000, 32'h100, 32'h1000},
    parameter logic [5:0]   BAR_LEGACY    = 6'b001000,
    parameter logic [191:0] BAR_LEG_ADDR  = {32'h0, 32'h0, 32'h3F8, 32'h0, 32'h0, 32'h0}
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         req_valid,
    input  logic         req_write,
    input  logic [7:0]   req_offset,
    input  logic [2:0]   req_size,
    input  logic [31:0]  req_wdata,
    output logic         rsp_valid,
    output logic [31:0]  rsp_rdata,
    output logic         rsp_err,
    output logic [191:0] bar_base,
    output logic [5:0]   bar_enable,
    output logic         range_change
);
    localparam int IDX_W = $clog2(HDR_BYTES);

    logic        acc_ok;
    logic        wr_any, wr_b, wr_h, wr_w;
    logic [15:0] cmd_q, sts_q;
    logic [7:0]  cls_q, lat_q, intl_q;
    logic [31:0] rom_q;
    logic [NUM_BARS-1:0] bar_wr;
    logic [NUM_BARS-1:0] bar_chg;
    logic [31:0] bar_val [NUM_BARS];
    logic [7:0]  img [HDR_BYTES];
    logic [31:0] rd_word;
    logic [IDX_W-1:0] idx0, idx1, idx2, idx3;

    logic        rsp_valid_q, rsp_err_q;
    logic [31:0] rsp_rdata_q;

    cfghdr_access_check #(.OFS_W(8), .LIMIT(HDR_BYTES)) u_check (
        .offset (req_offset),
        .size   (req_size),
        .ok     (acc_ok)
    );

    // Purpose: split a legal write by access width.
    always_comb begin
        wr_any = req_valid && req_write && acc_ok;
        wr_b   = wr_any && (req_size == SZ_BYTE);
        wr_h   = wr_any && (req_size == SZ_HALF);
        wr_w   = wr_any && (req_size == SZ_WORD);
    end

    for (genvar i = 0; i < NUM_BARS; i++) begin : g_bar
        // Purpose: decode a 4-byte write aimed at this BAR.
        always_comb bar_wr[i] = wr_w && (req_offset == OFS_BAR0 + 8'(4 * i));

        cfghdr_bar #(
            .INIT        (BAR_INIT[32*i +: 32]),
            .SIZE        (BAR_SIZE[32*i +: 32]),
            .LEGACY      (BAR_LEGACY[i]),
            .LEGACY_ADDR (BAR_LEG_ADDR[32*i +: 32])
        ) u_bar (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (bar_wr[i]),
            .wdata   (req_wdata),
            .reg_val (bar_val[i]),
            .base    (bar_base[32*i +: 32]),
            .enable  (bar_enable[i]),
            .chg     (bar_chg[i])
        );
    end

    // Purpose: apply width-filtered writes to the plain writable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q  <= CMD_INIT;
            sts_q  <= STS_INIT;
            cls_q  <= CLS_INIT;
            lat_q  <= LAT_INIT;
            intl_q <= INT_LINE_INIT;
            rom_q  <= ROM_INIT;
        end else begin
            if (wr_b) begin
                case (req_offset)
                    OFS_CLS:      cls_q  <= req_wdata[7:0];
                    OFS_LAT:      lat_q  <= req_wdata[7:0];
                    OFS_INT_LINE: intl_q <= req_wdata[7:0];
                    default: ;
                endcase
            end
            if (wr_h) begin
                case (req_offset)
                    OFS_CMD: cmd_q <= req_wdata[15:0];
                    OFS_STS: sts_q <= req_wdata[15:0];
                    OFS_CLS: cls_q <= req_wdata[7:0];
                    default: ;
                endcase
            end
            if (wr_w) begin
                case (req_offset)
                    OFS_CMD: cmd_q <= req_wdata[15:0];
                    OFS_ROM: rom_q <= (req_wdata == ROM_SIZE_REQ) ? 32'hFFFF_FFFF : req_wdata;
                    default: ;
                endcase
            end
        end
    end

    // Purpose: assemble the byte-addressed header image.
    always_comb begin
        for (int b = 0; b < HDR_BYTES; b++) img[b] = 8'h00;
        {img[1], img[0]}   = VENDOR_ID;
        {img[3], img[2]}   = DEVICE_ID;
        {img[5], img[4]}   = cmd_q;
        {img[7], img[6]}   = sts_q;
        img[8]             = REVISION;
        {img[11], img[10], img[9]} = CLASS_CODE;
        img[12]            = cls_q;
        img[13]            = lat_q;
        img[14]            = HDR_TYPE;
        img[15]            = BIST_VAL;
        for (int n = 0; n < NUM_BARS; n++) begin
            for (int k = 0; k < 4; k++) img[16 + 4*n + k] = bar_val[n][8*k +: 8];
        end
        {img[43], img[42], img[41], img[40]} = CIS_PTR;
        {img[45], img[44]} = SUBSYS_VID;
        {img[47], img[46]} = SUBSYS_ID;
        {img[51], img[50], img[49], img[48]} = rom_q;
        img[60]            = intl_q;
        img[61]            = INT_PIN;
        img[62]            = MIN_GRANT;
        img[63]            = MAX_LATENCY;
    end

    // Purpose: gather up to four bytes at the offset and mask by size.
    always_comb begin
        idx0 = req_offset[IDX_W-1:0];
        idx1 = idx0 + IDX_W'(1);
        idx2 = idx0 + IDX_W'(2);
        idx3 = idx0 + IDX_W'(3);
        case (req_size)
            SZ_BYTE: rd_word = {24'h0, img[idx0]};
            SZ_HALF: rd_word = {16'h0, img[idx1], img[idx0]};
            default: rd_word = {img[idx3], img[idx2], img[idx1], img[idx0]};
        endcase
    end

    // Purpose: register the one-cycle response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid_q <= 1'b0;
            rsp_err_q   <= 1'b0;
            rsp_rdata_q <= 32'h0;
        end else begin
            rsp_valid_q <= req_valid;
            rsp_err_q   <= req_valid && !acc_ok;
            rsp_rdata_q <= (req_valid && !req_write && acc_ok) ? rd_word : 32'h0;
        end
    end

    // Purpose: drive response and change-pulse outputs.
    always_comb begin
        rsp_valid    = rsp_valid_q;
        rsp_err      = rsp_err_q;
        rsp_rdata    = rsp_rdata_q;
        range_change = |bar_chg;
    end

    p_rsp_one_cycle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    p_no_spurious_rsp_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    p_illegal_holds_state_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !acc_ok) |=> ($stable(cmd_q) && $stable(sts_q) && $stable(cls_q)
                                    && $stable(lat_q) && $stable(intl_q) && $stable(rom_q)));

    p_pulse_with_rsp_r9: assert property (@(posedge clk) disable iff (!rst_n)
        range_change |-> (rsp_valid && !rsp_err));

    p_rom_size_code_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_w && req_offset == OFS_ROM && req_wdata == ROM_SIZE_REQ) |=> (rom_q == 32'hFFFF_FFFF));
endmodule

// File: tb/cfghdr_regs_bench.sv
// Bench: scoreboard for cfghdr_regs. A driver task queues the expected
// response, and a monitor compares it against the design at each negedge.
module cfghdr_regs_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_write = 1'b0;
    logic [7:0]   req_offset = 8'h0;
    logic [2:0]   req_size = 3'd4;
    logic [31:0]  req_wdata = 32'h0;
    logic         rsp_valid, rsp_err, range_change;
    logic [31:0]  rsp_rdata;
    logic [191:0] bar_base;
    logic [5:0]   bar_enable;

    int n_cmp = 0;
    int n_bad = 0;

    typedef struct {
        logic [31:0] rdata;
        logic        err;
        logic        pulse;
        string       tag;
    } exp_t;
    exp_t sb_q [$];

    always #2.5 clk = ~clk;

    cfghdr_regs u_cfghdr_regs (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_offset(req_offset), .req_size(req_size), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
        .bar_base(bar_base), .bar_enable(bar_enable), .range_change(range_change)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Driver: present one request at a negedge and queue its expected response.
    task automatic acc(input logic wr, input logic [7:0] ofs, input logic [2:0] sz,
                       input logic [31:0] wd, input logic [31:0] exp_rd,
                       input logic exp_err, input logic exp_pulse, input string tag);
        exp_t e;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_offset = ofs; req_size = sz; req_wdata = wd;
        e.rdata = exp_rd; e.err = exp_err; e.pulse = exp_pulse; e.tag = tag;
        sb_q.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
        end
    endtask

    task automatic rd(input logic [7:0] ofs, input logic [2:0] sz, input logic [31:0] exp_rd, input string tag);
        acc(1'b0, ofs, sz, 32'h0, exp_rd, 1'b0, 1'b0, tag);
        idle(1);
    endtask

    task automatic wr(input logic [7:0] ofs, input logic [2:0] sz, input logic [31:0] wd,
                      input logic pulse, input string tag);
        acc(1'b1, ofs, sz, wd, 32'h0, 1'b0, pulse, tag);
        idle(1);
    endtask

    // Monitor: pop and compare each response; also flag range_change without a response.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (sb_q.size() == 0) begin
                check("R12 unexpected response", 64'(rsp_valid), 64'h0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check({e.tag, " rdata"}, 64'(rsp_rdata), 64'(e.rdata));
                check({e.tag, " err"}, 64'(rsp_err), 64'(e.err));
                check({e.tag, " R9 range_change"}, 64'(range_change), 64'(e.pulse));
            end
        end else if (rst_n) begin
            if (range_change) check("R9 pulse without response", 64'(range_change), 64'h0);
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset values
        rd(8'h00, 3'd4, 32'h0417_A5C3, "R1 vendor/device");
        rd(8'h08, 3'd4, 32'h0280_0002, "R1 rev/class");
        rd(8'h3C, 3'd4, 32'h1004_010B, "R1 interrupt word");
        rd(8'h2C, 3'd4, 32'h0001_A5C3, "R1 subsystem");
        rd(8'h34, 3'd4, 32'h0, "R1 reserved zero");
        rd(8'h10, 3'd4, 32'h0, "R1 BAR0 init");
        rd(8'h14, 3'd4, 32'h1, "R1 BAR1 init");
        // R2 sizes
        rd(8'h02, 3'd2, 32'h0417, "R2 half device");
        rd(8'h06, 3'd2, 32'h0290, "R2 half status");
        rd(8'h3D, 3'd1, 32'h01, "R2 byte int pin");
        rd(8'h0B, 3'd1, 32'h02, "R2 byte class");
        // R10 legacy decode after reset
        check("R10 enable after reset", 64'(bar_enable), 64'(6'b001000));
        check("R10 legacy base", 64'(bar_base[3*32 +: 32]), 64'h3F8);
        // R3 illegal accesses
        acc(1'b0, 8'h40, 3'd4, 0, 0, 1'b1, 1'b0, "R3 offset 0x40"); idle(1);
        acc(1'b0, 8'h00, 3'd3, 0, 0, 1'b1, 1'b0, "R3 size 3"); idle(1);
        acc(1'b0, 8'h01, 3'd2, 0, 0, 1'b1, 1'b0, "R3 odd half"); idle(1);
        acc(1'b1, 8'h06, 3'd4, 32'hFFFF_FFFF, 0, 1'b1, 1'b0, "R3 misaligned word write"); idle(1);
        acc(1'b1, 8'h41, 3'd1, 32'hFF, 0, 1'b1, 1'b0, "R3 write beyond header"); idle(1);
        rd(8'h04, 3'd4, 32'h0290_0000, "R3 state unchanged");
        // R4 byte writes
        wr(8'h3C, 3'd1, 32'h55, 1'b0, "R4 int line write");
        wr(8'h0D, 3'd1, 32'h40, 1'b0, "R4 latency write");
        wr(8'h0C, 3'd1, 32'h10, 1'b0, "R4 cache line write");
        wr(8'h3D, 3'd1, 32'hEE, 1'b0, "R4 int pin write");
        wr(8'h08, 3'd1, 32'hEE, 1'b0, "R4 revision write");
        wr(8'h00, 3'd1, 32'hEE, 1'b0, "R4 vendor byte write");
        rd(8'h3C, 3'd1, 32'h55, "R4 int line readback");
        rd(8'h0C, 3'd4, 32'h0000_4010, "R4 cls/lat readback");
        rd(8'h3D, 3'd1, 32'h01, "R4 int pin dropped");
        rd(8'h08, 3'd1, 32'h02, "R4 revision dropped");
        rd(8'h00, 3'd2, 32'hA5C3, "R4 vendor dropped");
        // R5 half writes
        wr(8'h04, 3'd2, 32'h0147, 1'b0, "R5 command write");
        wr(8'h06, 3'd2, 32'h1234, 1'b0, "R5 status write");
        wr(8'h0C, 3'd2, 32'hBB22, 1'b0, "R5 cls via half");
        wr(8'h02, 3'd2, 32'hBEEF, 1'b0, "R5 device half write");
        rd(8'h04, 3'd4, 32'h1234_0147, "R5 cmd/status readback");
        rd(8'h0C, 3'd2, 32'h4022, "R5 cls low byte only");
        rd(8'h02, 3'd2, 32'h0417, "R5 device dropped");
        // R6 word writes, R12 back-to-back write then read
        acc(1'b1, 8'h04, 3'd4, 32'hDEAD_0006, 0, 1'b0, 1'b0, "R6 command word write");
        acc(1'b0, 8'h04, 3'd4, 0, 32'h1234_0006, 1'b0, 1'b0, "R6 R12 back-to-back read");
        idle(1);
        wr(8'h00, 3'd4, 32'h0, 1'b0, "R6 id word write");
        wr(8'h3C, 3'd4, 32'hFFFF_FFFF, 1'b0, "R6 int word write");
        rd(8'h00, 3'd4, 32'h0417_A5C3, "R6 id dropped");
        rd(8'h3C, 3'd4, 32'h1004_0155, "R6 int word dropped");
        // R7 sizing
        wr(8'h10, 3'd4, 32'hFFFF_FFFF, 1'b0, "R7 size BAR0");
        wr(8'h14, 3'd4, 32'hFFFF_FFFF, 1'b0, "R7 size BAR1");
        wr(8'h18, 3'd4, 32'hFFFF_FFFF, 1'b0, "R7 size BAR2");
        wr(8'h20, 3'd4, 32'hFFFF_FFFF, 1'b0, "R7 size BAR4");
        rd(8'h10, 3'd4, 32'hFFFF_F000, "R7 BAR0 mask");
        rd(8'h14, 3'd4, 32'hFFFF_FF01, "R7 BAR1 io mask");
        rd(8'h18, 3'd4, 32'hFFF0_0008, "R7 BAR2 prefetch mask");
        rd(8'h20, 3'd4, 32'h0, "R7 unused BAR4");
        check("R7 no enable from sizing", 64'(bar_enable), 64'(6'b001000));
        // R8/R9 address programming
        wr(8'h10, 3'd4, 32'h8000_0005, 1'b1, "R8 R9 program BAR0");
        wr(8'h14, 3'd4, 32'h0000_C0F2, 1'b1, "R8 R9 program BAR1");
        wr(8'h18, 3'd4, 32'h4000_0000, 1'b1, "R8 R9 program BAR2");
        rd(8'h10, 3'd4, 32'h8000_0000, "R8 BAR0 value");
        rd(8'h14, 3'd4, 32'h0000_C0F1, "R8 BAR1 io type kept");
        rd(8'h18, 3'd4, 32'h4000_0008, "R8 BAR2 mem type kept");
        check("R9 enables", 64'(bar_enable), 64'(6'b001111));
        check("R9 BAR0 base", 64'(bar_base[0 +: 32]), 64'h8000_0000);
        check("R9 BAR1 base", 64'(bar_base[32 +: 32]), 64'h0000_C0F0);
        check("R9 BAR2 base", 64'(bar_base[64 +: 32]), 64'h4000_0000);
        wr(8'h10, 3'd4, 32'hFFFF_FFFF, 1'b0, "R7 resize BAR0");
        rd(8'h10, 3'd4, 32'hFFFF_F000, "R7 BAR0 mask again");
        check("R7 base kept on sizing", 64'(bar_base[0 +: 32]), 64'h8000_0000);
        wr(8'h10, 3'd4, 32'h0000_0000, 1'b0, "R9 zero address write");
        rd(8'h10, 3'd4, 32'h0, "R9 BAR0 reads zero");
        check("R9 base kept on zero", 64'(bar_base[0 +: 32]), 64'h8000_0000);
        check("R9 enable kept on zero", 64'(bar_enable[0]), 64'h1);
        // R10 legacy BAR
        wr(8'h1C, 3'd4, 32'h1234_5678, 1'b0, "R10 legacy write");
        wr(8'h1C, 3'd4, 32'hFFFF_FFFF, 1'b0, "R10 legacy sizing");
        rd(8'h1C, 3'd4, 32'h0, "R10 legacy reads zero");
        check("R10 legacy base fixed", 64'(bar_base[3*32 +: 32]), 64'h3F8);
        // R11 expansion ROM
        wr(8'h30, 3'd4, 32'hFFFF_FFFE, 1'b0, "R11 rom size code");
        rd(8'h30, 3'd4, 32'hFFFF_FFFF, "R11 rom all ones");
        wr(8'h30, 3'd4, 32'h000C_0001, 1'b0, "R11 rom store");
        rd(8'h30, 3'd4, 32'h000C_0001, "R11 rom readback");
        // R12 drain: every queued response must have arrived
        idle(4);
        check("R12 queue drained", 64'(sb_q.size()), 64'h0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule